// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small fully associative cache of page translations that sits between a processor's address generator and its memory path. Each request presents a logical address, the requester's process number and the kind of access wanted. The block splits the address at a fixed power-of-two page boundary. It compares the page number against every stored entry at once and returns, one cycle later, a physical address. That address is made of the stored frame number and the original in-page offset. The response also carries a hit, miss or permission-fault indication.

Entries are written through a fill port whenever software or a table walker has resolved a translation. Fills take the lowest free slot, and once the cache is full a rotating pointer picks the entry to overwrite. A flush command clears the whole cache and is meant to be issued after any change to the page tables. Each entry carries a process tag. Process number zero on either side acts as a wildcard, so global mappings and privileged requesters can share entries across processes.

Top module: `pxb_top`

## Requirements
- R1: After reset every entry is invalid and rsp_valid, rsp_hit, rsp_miss and rsp_fault are all low.
- R2: The page number is lk_vaddr[31:11] and the offset is lk_vaddr[10:0]. On a hit rsp_paddr is {frame[20:0], offset}, with the offset copied unchanged.
- R3: rsp_valid is high in the cycle after a cycle with lk_valid high and low otherwise. While rsp_valid is high exactly one of rsp_hit and rsp_miss is high. While it is low, hit, miss and fault are all low.
- R4: An entry whose valid bit is clear never matches. A lookup with no matching entry gives rsp_miss and an rsp_paddr of zero.
- R5: An entry matches only if its page number equals the request's page number and its process tag equals lk_pid, or either of the two tags is zero.
- R6: Permission and access bits share one encoding: bit 0 is read, bit 1 is write, bit 2 is execute. On a hit, rsp_fault is high when lk_acc has any bit set that the entry's permission field lacks. rsp_hit and rsp_paddr are still given on a fault.
- R7: When several entries match, the response uses the one with the lowest index.
- R8: A fill while some entry is invalid writes the lowest-indexed invalid entry.
- R9: A fill while all entries are valid overwrites the entry named by a rotating pointer. The pointer is zero after reset, steps by one after each such overwrite and wraps after the last entry. A flush does not move it.
- R10: A flush clears every valid bit at the clock edge. A lookup in the same cycle still sees the old contents. A fill in the same cycle as a flush is discarded.
- R11: A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Logical address to translate |
| lk_pid | input | 8 | Process number of the requester |
| lk_acc | input | 3 | Requested access (read, write, execute) |
| fill_valid | input | 1 | Write a new entry |
| fill_vpn | input | 21 | Page number of the new entry |
| fill_pid | input | 8 | Process tag of the new entry (0 = global) |
| fill_frame | input | 21 | Physical frame number of the new entry |
| fill_perm | input | 3 | Permissions of the new entry |
| flush | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Hit with an access the entry forbids |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The assertions expect rst_n to be held low for at least one clock edge before any request. They also expect every input to be at a known level from the end of reset on, because the latency and exclusivity properties compare the response against the request strobe one edge earlier. The bench holds all strobes low during reset. It changes inputs only on the falling edge and returns every strobe to zero after each one-cycle operation, so no request is ever left undefined. Fills and lookups use only values that fit the stated field widths.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    localparam int NUM_ENT   = 8;
    localparam int LA_W      = 32;
    localparam int PAGE_BITS = 11;
    localparam int PID_W     = 8;
    localparam int PERM_W    = 3;
    localparam int VPN_W     = LA_W - PAGE_BITS;
    localparam int FRAME_W   = LA_W - PAGE_BITS;
    localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef struct packed {
        logic               vld;
        logic [VPN_W-1:0]   vpn;
        logic [PID_W-1:0]   pid;
        logic [FRAME_W-1:0] frame;
        logic [PERM_W-1:0]  perm;
    } pxb_ent_t;
endpackage

// File: rtl/pxb_match.sv
module pxb_match
    import pxb_pkg::*;
#(
    parameter int N = NUM_ENT
) (
    input  pxb_ent_t         ents [N],
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic [N-1:0]     hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic tag_ok;
        assign tag_ok = (ents[g].pid == pid) || (ents[g].pid == '0) || (pid == '0);
        assign hit_vec[g] = ents[g].vld && (ents[g].vpn == vpn) && tag_ok;
    end
endmodule

// File: rtl/pxb_prio.sv
module pxb_prio
    import pxb_pkg::*;
#(
    parameter int N = NUM_ENT,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pxb_victim.sv
module pxb_victim
    import pxb_pkg::*;
#(
    parameter int N = NUM_ENT,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  valid_vec,
    input  logic          fill_go,
    output logic [IW-1:0] vic_idx
);
    typedef struct packed {
        logic [IW-1:0] rr;
    } vic_st_t;

    vic_st_t st_d, st_q;
    logic          free_found;
    logic [IW-1:0] free_idx;

    pxb_prio #(.N(N)) u_free (
        .req   (~valid_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    always_comb begin
        st_d    = st_q;
        vic_idx = free_found ? free_idx : st_q.rr;
        if (fill_go && !free_found) begin
            if (st_q.rr == IW'(N - 1)) st_d.rr = '0;
            else                       st_d.rr = st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    vic_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !(&valid_vec)) |-> !valid_vec[vic_idx]);
endmodule

// File: rtl/pxb_top.sv
module pxb_top
    import pxb_pkg::*;
#(
    parameter int N = NUM_ENT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [LA_W-1:0]     lk_vaddr,
    input  logic [PID_W-1:0]    lk_pid,
    input  logic [PERM_W-1:0]   lk_acc,
    input  logic                fill_valid,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PID_W-1:0]    fill_pid,
    input  logic [FRAME_W-1:0]  fill_frame,
    input  logic [PERM_W-1:0]   fill_perm,
    input  logic                flush,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic                rsp_fault,
    output logic [LA_W-1:0]     rsp_paddr
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct {
        pxb_ent_t        ent [N];
        logic            rv;
        logic            hit;
        logic            miss;
        logic            fault;
        logic [LA_W-1:0] pa;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [VPN_W-1:0]     req_vpn;
    logic [PAGE_BITS-1:0] req_off;
    logic [N-1:0]         hit_vec;
    logic [N-1:0]         valid_vec;
    logic                 any_hit;
    logic [IW-1:0]        hit_idx;
    logic [IW-1:0]        vic_idx;
    logic                 fill_go;
    pxb_ent_t             sel;

    assign req_vpn = lk_vaddr[LA_W-1:PAGE_BITS];
    assign req_off = lk_vaddr[PAGE_BITS-1:0];
    assign fill_go = fill_valid && !flush;

    for (genvar g = 0; g < N; g++) begin : g_vld
        assign valid_vec[g] = st_q.ent[g].vld;
    end

    pxb_match #(.N(N)) u_match (
        .ents    (st_q.ent),
        .vpn     (req_vpn),
        .pid     (lk_pid),
        .hit_vec (hit_vec)
    );

    pxb_prio #(.N(N)) u_sel (
        .req   (hit_vec),
        .found (any_hit),
        .idx   (hit_idx)
    );

    pxb_victim #(.N(N)) u_vic (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .fill_go   (fill_go),
        .vic_idx   (vic_idx)
    );

    assign sel = st_q.ent[hit_idx];

    always_comb begin
        st_d       = st_q;
        st_d.rv    = lk_valid;
        st_d.hit   = lk_valid && any_hit;
        st_d.miss  = lk_valid && !any_hit;
        st_d.fault = lk_valid && any_hit && ((lk_acc & ~sel.perm) != '0);
        st_d.pa    = (lk_valid && any_hit) ? {sel.frame, req_off} : '0;
        if (flush) begin
            for (int i = 0; i < N; i++) st_d.ent[i].vld = 1'b0;
        end else if (fill_valid) begin
            st_d.ent[vic_idx].vld   = 1'b1;
            st_d.ent[vic_idx].vpn   = fill_vpn;
            st_d.ent[vic_idx].pid   = fill_pid;
            st_d.ent[vic_idx].frame = fill_frame;
            st_d.ent[vic_idx].perm  = fill_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) st_q.ent[i] <= '0;
            st_q.rv    <= 1'b0;
            st_q.hit   <= 1'b0;
            st_q.miss  <= 1'b0;
            st_q.fault <= 1'b0;
            st_q.pa    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.hit;
    assign rsp_miss  = st_q.miss;
    assign rsp_fault = st_q.fault;
    assign rsp_paddr = st_q.pa;

    // R3
    rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R3
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault));
    // R3
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss));
    // R6
    fault_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);
    // R4
    miss_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0));
    // R2
    offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0])));
    // R10
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
endmodule

// File: tb/pxb_top_bench.sv
`timescale 1ns/1ps
module pxb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_pid;
    logic [2:0]  lk_acc;
    logic        fill_valid;
    logic [20:0] fill_vpn;
    logic [7:0]  fill_pid;
    logic [20:0] fill_frame;
    logic [2:0]  fill_perm;
    logic        flush;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pxb_top u_pxb_top (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_acc(lk_acc),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_frame(fill_frame), .fill_perm(fill_perm), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    localparam logic [1:0] OP_FILL = 2'd1;
    localparam logic [1:0] OP_LOOK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [7:0]  pid;
        logic [20:0] frame;
        logic [2:0]  bits;
        logic        eh;
        logic        ef;
        logic [31:0] epa;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{OP_LOOK, 32'h0000_1234, 8'd1, 21'h0,      3'd1, 1'b0, 1'b0, 32'h0,        8'd4},  // R4 empty
        '{OP_FILL, 32'h0040_0000, 8'd1, 21'h123,    3'd3, 1'b0, 1'b0, 32'h0,        8'd8},
        '{OP_LOOK, 32'h0040_07FF, 8'd1, 21'h0,      3'd1, 1'b1, 1'b0, 32'h0009_1FFF, 8'd2}, // R2
        '{OP_LOOK, 32'h0040_0005, 8'd2, 21'h0,      3'd1, 1'b0, 1'b0, 32'h0,        8'd5},  // R5 tag differs
        '{OP_LOOK, 32'h0040_0005, 8'd0, 21'h0,      3'd1, 1'b1, 1'b0, 32'h0009_1805, 8'd5}, // R5 requester zero
        '{OP_LOOK, 32'h0040_0005, 8'd1, 21'h0,      3'd4, 1'b1, 1'b1, 32'h0009_1805, 8'd6}, // R6 exec denied
        '{OP_LOOK, 32'h0040_0005, 8'd1, 21'h0,      3'd2, 1'b1, 1'b0, 32'h0009_1805, 8'd6}, // R6 write ok
        '{OP_FILL, 32'h0080_0000, 8'd0, 21'hABC,    3'd7, 1'b0, 1'b0, 32'h0,        8'd8},
        '{OP_LOOK, 32'h0080_0010, 8'd9, 21'h0,      3'd4, 1'b1, 1'b0, 32'h0055_E010, 8'd5}, // R5 entry zero
        '{OP_FILL, 32'h0080_0000, 8'd9, 21'h555,    3'd1, 1'b0, 1'b0, 32'h0,        8'd8},
        '{OP_LOOK, 32'h0080_0010, 8'd9, 21'h0,      3'd4, 1'b1, 1'b0, 32'h0055_E010, 8'd7}, // R7
        '{OP_FILL, 32'h00C0_0000, 8'd4, 21'h1FFFFF, 3'd1, 1'b0, 1'b0, 32'h0,        8'd8},
        '{OP_LOOK, 32'h00C0_07FF, 8'd4, 21'h0,      3'd1, 1'b1, 1'b0, 32'hFFFF_FFFF, 8'd2}, // R2 top
        '{OP_LOOK, 32'h00C0_0800, 8'd4, 21'h0,      3'd1, 1'b0, 1'b0, 32'h0,        8'd2}   // R2 next page
    };

    task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic clear_in();
        lk_valid = 1'b0; lk_vaddr = '0; lk_pid = '0; lk_acc = '0;
        fill_valid = 1'b0; fill_vpn = '0; fill_pid = '0; fill_frame = '0; fill_perm = '0;
        flush = 1'b0;
    endtask

    task automatic set_look(input logic [31:0] a, input logic [7:0] p, input logic [2:0] acc);
        lk_valid = 1'b1; lk_vaddr = a; lk_pid = p; lk_acc = acc;
    endtask

    task automatic set_fill(input logic [20:0] v, input logic [7:0] p, input logic [20:0] f, input logic [2:0] pm);
        fill_valid = 1'b1; fill_vpn = v; fill_pid = p; fill_frame = f; fill_perm = pm;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_in();
    endtask

    task automatic chk_rsp(input int rq, input logic eh, input logic ef, input logic [31:0] epa);
        check(rq, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check(rq, "rsp_hit",   {31'b0, rsp_hit},   {31'b0, eh});
        check(rq, "rsp_miss",  {31'b0, rsp_miss},  {31'b0, !eh});
        check(rq, "rsp_fault", {31'b0, rsp_fault}, {31'b0, ef});
        check(rq, "rsp_paddr", rsp_paddr, epa);
    endtask

    task automatic look(input logic [31:0] a, input logic [7:0] p, input logic [2:0] acc,
                        input int rq, input logic eh, input logic ef, input logic [31:0] epa);
        set_look(a, p, acc);
        tick();
        chk_rsp(rq, eh, ef, epa);
    endtask

    task automatic fill(input logic [20:0] v, input logic [7:0] p, input logic [20:0] f, input logic [2:0] pm);
        set_fill(v, p, f, pm);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(1, "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check(1, "rsp_hit",   {31'b0, rsp_hit},   32'd0);
        check(1, "rsp_miss",  {31'b0, rsp_miss},  32'd0);
        check(1, "rsp_fault", {31'b0, rsp_fault}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == OP_FILL) begin
                fill(VEC[i].addr[31:11], VEC[i].pid, VEC[i].frame, VEC[i].bits);
            end else begin
                look(VEC[i].addr, VEC[i].pid, VEC[i].bits, int'(VEC[i].rq),
                     VEC[i].eh, VEC[i].ef, VEC[i].epa);
            end
        end

        // R3 idle cycle gives no response
        tick();
        check(3, "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check(3, "idle rsp_hit",   {31'b0, rsp_hit},   32'd0);

        // R10 lookup alongside flush sees old contents, later lookup misses
        set_look(32'h0040_0005, 8'd1, 3'd1);
        flush = 1'b1;
        tick();
        chk_rsp(10, 1'b1, 1'b0, 32'h0009_1805);
        look(32'h0040_0005, 8'd1, 3'd1, 10, 1'b0, 1'b0, 32'h0);
        // R10 fill with flush is discarded
        set_fill(21'h5, 8'd1, 21'h9, 3'd1);
        flush = 1'b1;
        tick();
        look(32'h0000_2800, 8'd1, 3'd1, 10, 1'b0, 1'b0, 32'h0);

        // R11 lookup alongside fill sees old contents
        set_fill(21'h6, 8'd1, 21'hA, 3'd1);
        set_look(32'h0000_3003, 8'd1, 3'd1);
        tick();
        chk_rsp(11, 1'b0, 1'b0, 32'h0);
        look(32'h0000_3003, 8'd1, 3'd1, 11, 1'b1, 1'b0, 32'h0000_5003);

        // R8 fills land in lowest free slot, seen through priority order
        flush = 1'b1;
        tick();
        fill(21'h300, 8'd3, 21'h11, 3'd1);
        fill(21'h300, 8'd0, 21'h22, 3'd1);
        look({21'h300, 11'h0}, 8'd3, 3'd1, 8, 1'b1, 1'b0, 32'h0000_8800);
        look({21'h300, 11'h0}, 8'd7, 3'd1, 8, 1'b1, 1'b0, 32'h0001_1000);
        look({21'h300, 11'h0}, 8'd0, 3'd1, 8, 1'b1, 1'b0, 32'h0000_8800);

        // R9 rotating replacement once full
        flush = 1'b1;
        tick();
        for (int k = 0; k < 8; k++) fill(21'h100 + 21'(k), 8'd1, 21'h40 + 21'(k), 3'd1);
        fill(21'h200, 8'd1, 21'h77, 3'd1);
        look({21'h100, 11'h0}, 8'd1, 3'd1, 9, 1'b0, 1'b0, 32'h0);
        look({21'h200, 11'h0}, 8'd1, 3'd1, 9, 1'b1, 1'b0, 32'h0003_B800);
        fill(21'h201, 8'd1, 21'h78, 3'd1);
        look({21'h101, 11'h0}, 8'd1, 3'd1, 9, 1'b0, 1'b0, 32'h0);
        look({21'h102, 11'h0}, 8'd1, 3'd1, 9, 1'b1, 1'b0, 32'h0002_1000);
        look({21'h201, 11'h0}, 8'd1, 3'd1, 9, 1'b1, 1'b0, 32'h0003_C000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule